// File: doc/BRIEF.md
# Windowed Pixel Transfer Engine

This block controls the loading of one rectangular pixel window into a linear framebuffer. Software sets an input format code and the inclusive start and end corners of a window. A transfer is then armed in one of two ways: by a write to the source-select register, or on demand by the first data word that arrives while no transfer is pending. The block validates the setup and computes how many 16-bit data words the window occupies. It counts the words as they come in. When the last word has been taken, it walks the window row by row and puts out one framebuffer byte address per row.

Each committed window enlarges a dirty bounding box, which a later display refresh consumes. A refresh request is granted only when the box is non-empty. A granted refresh returns the box to its empty form, in which each minimum sits at the display size and each maximum sits at zero. Word data travels beside this block. The block itself carries only the counting, validation, addressing and region tracking.

If a source-select write and a data word arrive in the same cycle, the source-select write takes effect and the data word is not counted.

Top module: `pxw_top`

## Requirements
- R1: `fmtWr` loads `fmtIn` into the format register. The bytes per pixel are 2 for code 1, 3 for codes 2 and 3, and 4 for codes 6 and 7. Every other code, including the YUV codes 8 and 9, gives 0, which marks the format as unsupported.
- R2: A setup is refused when the source value is above 3, when the bytes per pixel are 0, when `xEnd` < `xStart`, or when `yEnd` < `yStart`. The source value is `srcIn` on a source-select write and the stored source otherwise. A refused setup leaves `busy` and `wordsLeft` unchanged.
- R3: A successful setup sets `wordsLeft` to floor(bpp × (xEnd−xStart+1) × (yEnd−yStart+1) / 2) on the next clock edge, and `busy` rises.
- R4: A data word that arrives while idle first attempts a setup. If the setup succeeds, that word counts as the first word, and a one-word window commits at once. If it fails, the word is dropped and the block stays idle.
- R5: Each counted data word lowers `wordsLeft` by one. At the edge where the last word is taken, a commit begins. `fbWrEn` is then high for one cycle per window row, with `fbAddr` = ((yStart+row) × DISP_W + xStart) × OUT_BPP, taking row 0 upward.
- R6: On the edge where a commit begins, `minX` and `minY` are lowered to the window start, and `maxX` and `maxY` are raised to start+width and start+height.
- R7: `refreshGo` equals `refreshReq` while `maxX` > `minX` and is 0 otherwise. After a granted refresh, the box is empty: `minX`=DISP_W, `minY`=DISP_H, `maxX`=0, `maxY`=0.
- R8: After reset the format code is 3 (3 bytes per pixel) and the stored source is 0. The block is idle with `wordsLeft`=0, and the dirty box is empty.
- R9: `busy` is high from a successful setup until the last row address has been issued. Data words that arrive during the row walk are ignored. A successful source-select write during loading restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmtWr | input | 1 | Format register write strobe |
| fmtIn | input | 4 | Input format code |
| srcWr | input | 1 | Source-select write strobe; performs setup |
| srcIn | input | 3 | Source-select value |
| xStart | input | CW | Window left column, inclusive |
| xEnd | input | CW | Window right column, inclusive |
| yStart | input | CW | Window top row, inclusive |
| yEnd | input | CW | Window bottom row, inclusive |
| dataWr | input | 1 | Data-port word strobe |
| refreshReq | input | 1 | Display refresh request |
| busy | output | 1 | Transfer armed or committing |
| wordsLeft | output | 2*CW+4 | Remaining data words |
| fbWrEn | output | 1 | Row address valid |
| fbAddr | output | ADDR_W | Framebuffer byte address of the row start |
| refreshGo | output | 1 | Refresh granted this cycle |
| minX | output | CW+1 | Dirty box left bound |
| minY | output | CW+1 | Dirty box top bound |
| maxX | output | CW+1 | Dirty box right bound, exclusive |
| maxY | output | CW+1 | Dirty box bottom bound, exclusive |

## Verification
A wrong word count shows up on `wordsLeft` on the edge after setup. Later, it shows as a commit that comes one or more words early or late, and that offset is visible on `fbWrEn`. A corrupted latched corner or height shows up in the row addresses, and in the number of `fbWrEn` cycles within the few cycles that follow the final word. Errors in the bounding box are visible on the edge of the commit itself, or on the next refresh grant.

// File: rtl/pxw_pkg.sv
`timescale 1ns/1ps
package pxw_pkg;

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_LOAD   = 2'd1,
    XF_COMMIT = 2'd2
  } xfer_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setup;    // latch window and length
    logic take;     // count one data word
    logic commit;   // start row walk, widen dirty box
    logic rowStep;  // advance to next row
  } xfer_strobe_t;

  // Bytes per pixel for a format code; 0 means unsupported
  function automatic logic [2:0] fmtBytes(input logic [3:0] code);
    case (code)
      4'd1:       fmtBytes = 3'd2;
      4'd2, 4'd3: fmtBytes = 3'd3;
      4'd6, 4'd7: fmtBytes = 3'd4;
      default:    fmtBytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pxw_ctrl.sv
`timescale 1ns/1ps
module pxw_ctrl
  import pxw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srcWr,
  input  logic         dataWr,
  input  logic         setupOk,
  input  logic         lenIsOne,
  input  logic         cntIsOne,
  input  logic         rowLast,
  output xfer_strobe_t stb,
  output logic         busy,
  output logic         fbWrEn
);

  xfer_state_e state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      XF_IDLE: begin
        if (srcWr) begin
          if (setupOk) begin
            stb.setup = 1'b1;
            stateNext = XF_LOAD;
          end
        end else if (dataWr && setupOk) begin
          stb.setup = 1'b1;
          stb.take  = 1'b1;
          if (lenIsOne) begin
            stb.commit = 1'b1;
            stateNext  = XF_COMMIT;
          end else begin
            stateNext = XF_LOAD;
          end
        end
      end
      XF_LOAD: begin
        if (srcWr) begin
          if (setupOk) stb.setup = 1'b1;
        end else if (dataWr) begin
          stb.take = 1'b1;
          if (cntIsOne) begin
            stb.commit = 1'b1;
            stateNext  = XF_COMMIT;
          end
        end
      end
      XF_COMMIT: begin
        stb.rowStep = 1'b1;
        if (rowLast) stateNext = XF_IDLE;
      end
      default: stateNext = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= XF_IDLE;
    else        state <= stateNext;
  end

  assign busy   = (state != XF_IDLE);
  assign fbWrEn = (state == XF_COMMIT);

endmodule

// File: rtl/pxw_datapath.sv
`timescale 1ns/1ps
module pxw_datapath
  import pxw_pkg::*;
#(
  parameter int CW      = 10,
  parameter int DISP_W  = 64,
  parameter int DISP_H  = 48,
  parameter int OUT_BPP = 4,
  parameter int ADDR_W  = 20,
  localparam int BW     = CW + 1,
  localparam int LEN_W  = 2 * CW + 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmtWr,
  input  logic [3:0]        fmtIn,
  input  logic              srcWr,
  input  logic [2:0]        srcIn,
  input  logic [CW-1:0]     xStart,
  input  logic [CW-1:0]     xEnd,
  input  logic [CW-1:0]     yStart,
  input  logic [CW-1:0]     yEnd,
  input  logic              refreshReq,
  input  xfer_strobe_t      stb,
  output logic              setupOk,
  output logic              lenIsOne,
  output logic              cntIsOne,
  output logic              rowLast,
  output logic [LEN_W-1:0]  wordsLeft,
  output logic [ADDR_W-1:0] fbAddr,
  output logic              refreshGo,
  output logic [BW-1:0]     minX,
  output logic [BW-1:0]     minY,
  output logic [BW-1:0]     maxX,
  output logic [BW-1:0]     maxY
);

  localparam int PW = 2 * BW + 3;

  logic [3:0]       fmtReg;
  logic [2:0]       srcReg, srcCand, bpp;
  logic [BW-1:0]    wCfg, hCfg, wReg, hReg, rowIdx;
  logic [CW-1:0]    xsReg, ysReg;
  logic [PW-1:0]    prod;
  logic [LEN_W-1:0] lenCfg, cnt;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmtReg <= 4'd3;
      srcReg <= 3'd0;
    end else begin
      if (fmtWr) fmtReg <= fmtIn;
      if (srcWr) srcReg <= srcIn;
    end
  end

  // Setup validation and length
  assign srcCand  = srcWr ? srcIn : srcReg;
  assign bpp      = fmtBytes(fmtReg);
  assign wCfg     = BW'(xEnd) - BW'(xStart) + BW'(1);
  assign hCfg     = BW'(yEnd) - BW'(yStart) + BW'(1);
  assign prod     = PW'(bpp) * PW'(wCfg) * PW'(hCfg);
  assign lenCfg   = LEN_W'(prod >> 1);
  assign setupOk  = (srcCand <= 3'd3) && (bpp != 3'd0) &&
                    (xEnd >= xStart) && (yEnd >= yStart);
  assign lenIsOne = (lenCfg == LEN_W'(1));
  assign cntIsOne = (cnt == LEN_W'(1));
  assign rowLast  = (rowIdx == hReg - BW'(1));

  // Window latch, word counter and row walker
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xsReg  <= '0;
      ysReg  <= '0;
      wReg   <= '0;
      hReg   <= '0;
      cnt    <= '0;
      rowIdx <= '0;
    end else begin
      if (stb.setup) begin
        xsReg <= xStart;
        ysReg <= yStart;
        wReg  <= wCfg;
        hReg  <= hCfg;
        cnt   <= stb.take ? lenCfg - LEN_W'(1) : lenCfg;
      end else if (stb.take) begin
        cnt <= cnt - LEN_W'(1);
      end
      if (stb.commit)       rowIdx <= '0;
      else if (stb.rowStep) rowIdx <= rowIdx + BW'(1);
    end
  end

  assign wordsLeft = cnt;

  logic [31:0] rowAbs;
  assign rowAbs = 32'(ysReg) + 32'(rowIdx);
  assign fbAddr = ADDR_W'((rowAbs * 32'(DISP_W) + 32'(xsReg)) * 32'(OUT_BPP));

  // Dirty box: a lazy setup commits with the window being latched this cycle
  logic [BW-1:0] wxs, wys, wxe, wye, bMinX, bMinY, bMaxX, bMaxY;
  assign wxs = BW'(stb.setup ? xStart : xsReg);
  assign wys = BW'(stb.setup ? yStart : ysReg);
  assign wxe = wxs + (stb.setup ? wCfg : wReg);
  assign wye = wys + (stb.setup ? hCfg : hReg);

  assign refreshGo = refreshReq && (maxX > minX);
  assign bMinX = refreshGo ? BW'(DISP_W) : minX;
  assign bMinY = refreshGo ? BW'(DISP_H) : minY;
  assign bMaxX = refreshGo ? '0 : maxX;
  assign bMaxY = refreshGo ? '0 : maxY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      minX <= BW'(DISP_W);
      minY <= BW'(DISP_H);
      maxX <= '0;
      maxY <= '0;
    end else if (stb.commit) begin
      minX <= (wxs < bMinX) ? wxs : bMinX;
      minY <= (wys < bMinY) ? wys : bMinY;
      maxX <= (wxe > bMaxX) ? wxe : bMaxX;
      maxY <= (wye > bMaxY) ? wye : bMaxY;
    end else if (refreshGo) begin
      minX <= bMinX;
      minY <= bMinY;
      maxX <= bMaxX;
      maxY <= bMaxY;
    end
  end

endmodule

// File: rtl/pxw_top.sv
`timescale 1ns/1ps
module pxw_top
  import pxw_pkg::*;
#(
  parameter int CW      = 10,
  parameter int DISP_W  = 64,
  parameter int DISP_H  = 48,
  parameter int OUT_BPP = 4,
  parameter int ADDR_W  = 20,
  localparam int BW     = CW + 1,
  localparam int LEN_W  = 2 * CW + 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmtWr,
  input  logic [3:0]        fmtIn,
  input  logic              srcWr,
  input  logic [2:0]        srcIn,
  input  logic [CW-1:0]     xStart,
  input  logic [CW-1:0]     xEnd,
  input  logic [CW-1:0]     yStart,
  input  logic [CW-1:0]     yEnd,
  input  logic              dataWr,
  input  logic              refreshReq,
  output logic              busy,
  output logic [LEN_W-1:0]  wordsLeft,
  output logic              fbWrEn,
  output logic [ADDR_W-1:0] fbAddr,
  output logic              refreshGo,
  output logic [BW-1:0]     minX,
  output logic [BW-1:0]     minY,
  output logic [BW-1:0]     maxX,
  output logic [BW-1:0]     maxY
);

  xfer_strobe_t stb;
  logic setupOk, lenIsOne, cntIsOne, rowLast;

  pxw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .srcWr(srcWr), .dataWr(dataWr),
    .setupOk(setupOk), .lenIsOne(lenIsOne), .cntIsOne(cntIsOne),
    .rowLast(rowLast), .stb(stb), .busy(busy), .fbWrEn(fbWrEn)
  );

  pxw_datapath #(
    .CW(CW), .DISP_W(DISP_W), .DISP_H(DISP_H),
    .OUT_BPP(OUT_BPP), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .fmtWr(fmtWr), .fmtIn(fmtIn),
    .srcWr(srcWr), .srcIn(srcIn), .xStart(xStart), .xEnd(xEnd),
    .yStart(yStart), .yEnd(yEnd), .refreshReq(refreshReq), .stb(stb),
    .setupOk(setupOk), .lenIsOne(lenIsOne), .cntIsOne(cntIsOne),
    .rowLast(rowLast), .wordsLeft(wordsLeft), .fbAddr(fbAddr),
    .refreshGo(refreshGo), .minX(minX), .minY(minY), .maxX(maxX), .maxY(maxY)
  );

endmodule

// File: rtl/pxw_checker.sv
`timescale 1ns/1ps
module pxw_checker #(
  parameter int CW      = 10,
  parameter int DISP_W  = 64,
  parameter int OUT_BPP = 4,
  parameter int ADDR_W  = 20,
  localparam int BW     = CW + 1,
  localparam int LEN_W  = 2 * CW + 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              srcWr,
  input logic              dataWr,
  input logic              busy,
  input logic [LEN_W-1:0]  wordsLeft,
  input logic              fbWrEn,
  input logic [ADDR_W-1:0] fbAddr,
  input logic              refreshGo,
  input logic [BW-1:0]     minX,
  input logic [BW-1:0]     maxX
);

  a_r5_row_stride: assert property (@(posedge clk) disable iff (!rst_n)
    fbWrEn && $past(fbWrEn) |-> fbAddr == $past(fbAddr) + ADDR_W'(DISP_W * OUT_BPP));

  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fbWrEn && dataWr && !srcWr && wordsLeft > LEN_W'(1)
    |=> wordsLeft == $past(wordsLeft) - LEN_W'(1));

  a_r6_box_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !refreshGo |=> maxX >= $past(maxX));

  a_r7_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    refreshGo && !dataWr |=> maxX == '0 && minX == BW'(DISP_W));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> wordsLeft == '0 && !fbWrEn);

endmodule

bind pxw_top pxw_checker #(
  .CW(CW), .DISP_W(DISP_W), .OUT_BPP(OUT_BPP), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .srcWr(srcWr), .dataWr(dataWr), .busy(busy),
  .wordsLeft(wordsLeft), .fbWrEn(fbWrEn), .fbAddr(fbAddr),
  .refreshGo(refreshGo), .minX(minX), .maxX(maxX)
);

// File: tb/pxw_top_tb_top.sv
`timescale 1ns/1ps
module pxw_top_tb_top;

  localparam int CW = 10;
  localparam int LEN_W = 2 * CW + 4;
  localparam int BW = CW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmtWr = 1'b0, srcWr = 1'b0, dataWr = 1'b0, refreshReq = 1'b0;
  logic [3:0] fmtIn = '0;
  logic [2:0] srcIn = '0;
  logic [CW-1:0] xStart = '0, xEnd = '0, yStart = '0, yEnd = '0;
  logic busy, fbWrEn, refreshGo;
  logic [LEN_W-1:0] wordsLeft;
  logic [19:0] fbAddr;
  logic [BW-1:0] minX, minY, maxX, maxY;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  pxw_top dut_i (
    .clk(clk), .rst_n(rst_n), .fmtWr(fmtWr), .fmtIn(fmtIn), .srcWr(srcWr),
    .srcIn(srcIn), .xStart(xStart), .xEnd(xEnd), .yStart(yStart), .yEnd(yEnd),
    .dataWr(dataWr), .refreshReq(refreshReq), .busy(busy), .wordsLeft(wordsLeft),
    .fbWrEn(fbWrEn), .fbAddr(fbAddr), .refreshGo(refreshGo),
    .minX(minX), .minY(minY), .maxX(maxX), .maxY(maxY)
  );

  localparam int NV = 12;
  localparam int vFmt [NV] = '{1, 3, 2, 6, 7, 8, 9, 0, 4, 3, 3, 15};
  localparam int vXs  [NV] = '{0, 2, 0, 1, 0, 0, 0, 0, 0, 5, 0, 0};
  localparam int vXe  [NV] = '{3, 2, 2, 4, 0, 3, 3, 3, 3, 4, 0, 3};
  localparam int vYs  [NV] = '{0, 5, 0, 1, 0, 0, 0, 0, 0, 0, 6, 0};
  localparam int vYe  [NV] = '{1, 5, 0, 3, 0, 1, 1, 1, 1, 0, 5, 1};
  localparam int vExp [NV] = '{8, 1, 4, 24, 2, 0, 0, 0, 0, 0, 0, 0};

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
  endtask

  task automatic setFmt(input logic [3:0] f);
    fmtIn = f; fmtWr = 1'b1; tick(); fmtWr = 1'b0;
  endtask

  task automatic setWin(input int xs, input int xe, input int ys, input int ye);
    xStart = CW'(xs); xEnd = CW'(xe); yStart = CW'(ys); yEnd = CW'(ye);
  endtask

  task automatic pulseSrc(input logic [2:0] s);
    srcIn = s; srcWr = 1'b1; tick(); srcWr = 1'b0;
  endtask

  task automatic pulseData();
    dataWr = 1'b1; tick(); dataWr = 1'b0;
  endtask

  initial begin
    #1600000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // Reset state (R8)
    doReset();
    chk("R8 busy", int'(busy), 0);
    chk("R8 wordsLeft", int'(wordsLeft), 0);
    chk("R8 fbWrEn", int'(fbWrEn), 0);
    chk("R8 minX", int'(minX), 64);
    chk("R8 minY", int'(minY), 48);
    chk("R8 maxX", int'(maxX), 0);
    chk("R8 maxY", int'(maxY), 0);
    // Reset format is 3 bytes per pixel, source 0 accepted (R8)
    setWin(0, 1, 0, 0);
    pulseSrc(3'd0);
    chk("R8 default format length", int'(wordsLeft), 3);

    // Vector table: formats and refusals (R1, R3, R2)
    for (int i = 0; i < NV; i++) begin
      doReset();
      setFmt(4'(vFmt[i]));
      setWin(vXs[i], vXe[i], vYs[i], vYe[i]);
      pulseSrc(3'd0);
      if (vExp[i] == 0) begin
        chk("R2 refused length", int'(wordsLeft), 0);
        chk("R2 refused busy", int'(busy), 0);
      end else begin
        chk("R1/R3 length", int'(wordsLeft), vExp[i]);
        chk("R3 busy", int'(busy), 1);
      end
    end

    // Full transfer, fmt 1, 3x2 window at (3,2): 6 words (R5, R6, R9)
    doReset();
    setFmt(4'd1);
    setWin(3, 5, 2, 3);
    pulseSrc(3'd0);
    chk("R3 length 3x2", int'(wordsLeft), 6);
    repeat (5) pulseData();
    chk("R5 countdown", int'(wordsLeft), 1);
    chk("R5 no early commit", int'(fbWrEn), 0);
    pulseData();
    chk("R5 row0 en", int'(fbWrEn), 1);
    chk("R5 row0 addr", int'(fbAddr), 524);
    chk("R6 minX", int'(minX), 3);
    chk("R6 minY", int'(minY), 2);
    chk("R6 maxX", int'(maxX), 6);
    chk("R6 maxY", int'(maxY), 4);
    tick();
    chk("R5 row1 en", int'(fbWrEn), 1);
    chk("R5 row1 addr", int'(fbAddr), 780);
    chk("R9 busy during walk", int'(busy), 1);
    tick();
    chk("R9 busy after walk", int'(busy), 0);
    chk("R5 en after walk", int'(fbWrEn), 0);

    // Lazy arming, one-word window commits at once (R4, R6)
    setWin(10, 10, 0, 0);
    pulseData();
    chk("R4 lazy commit en", int'(fbWrEn), 1);
    chk("R4 lazy commit addr", int'(fbAddr), 40);
    chk("R6 union minX", int'(minX), 3);
    chk("R6 union minY", int'(minY), 0);
    chk("R6 union maxX", int'(maxX), 11);
    chk("R6 union maxY", int'(maxY), 4);
    tick();
    chk("R4 lazy done", int'(busy), 0);

    // Refresh grant and clearing (R7)
    refreshReq = 1'b1; #1;
    chk("R7 grant", int'(refreshGo), 1);
    tick(); refreshReq = 1'b0;
    chk("R7 minX empty", int'(minX), 64);
    chk("R7 minY empty", int'(minY), 48);
    chk("R7 maxX empty", int'(maxX), 0);
    chk("R7 maxY empty", int'(maxY), 0);
    refreshReq = 1'b1; #1;
    chk("R7 no grant when empty", int'(refreshGo), 0);
    tick(); refreshReq = 1'b0;

    // Source above 3 refused, lazy word then dropped (R2, R4)
    pulseSrc(3'd4);
    chk("R2 source 4 refused", int'(busy), 0);
    pulseData();
    chk("R4 dropped word busy", int'(busy), 0);
    chk("R4 dropped word count", int'(wordsLeft), 0);
    chk("R4 dropped word no commit", int'(fbWrEn), 0);

    // Restart while loading (R9)
    setWin(0, 3, 0, 0);
    pulseSrc(3'd0);
    chk("R3 length 4x1", int'(wordsLeft), 4);
    pulseData(); pulseData();
    chk("R5 two taken", int'(wordsLeft), 2);
    pulseSrc(3'd0);
    chk("R9 restart", int'(wordsLeft), 4);

    // Words during the row walk are ignored (R9)
    setWin(0, 0, 0, 2);
    pulseSrc(3'd0);
    chk("R3 length 1x3", int'(wordsLeft), 3);
    repeat (3) pulseData();
    chk("R5 walk row0", int'(fbAddr), 0);
    dataWr = 1'b1;
    tick(); tick();
    dataWr = 1'b0;
    chk("R5 walk row2", int'(fbAddr), 512);
    chk("R9 still walking", int'(fbWrEn), 1);
    tick();
    chk("R9 ignored words busy", int'(busy), 0);
    chk("R9 ignored words count", int'(wordsLeft), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule